// File: doc/BRIEF.md
# Register File with Delayed Load Write-Back

This block holds the architectural integer registers of a simple in-order core together with a single pending-load slot and a three-stage program-counter chain. A loaded value does not land in its target register when the load commits. It is parked in the pending slot and written only at the commit of the following instruction. That write is ordered after that instruction's own execute write, so on a collision the older load value wins.

Each commit moves the PC chain forward by one: the previous PC takes the current PC, the current PC takes the next PC, and the next PC takes either a supplied branch target or the next PC plus 4. This gives one branch delay slot. A link write stores the next PC plus 4 through the execute write port.

Before handing control to an exception handler, the surrounding core pulses a flush. The flush drains the pending load into the register file and empties the slot. It leaves the PC chain untouched.

Top module: `regfile_ldslot`

## Requirements
- R1: While `rst` is high at a clock edge, every register becomes 0, the pending slot becomes target 0 / value 0, `pc_prev` and `pc_cur` become `RESET_VEC`, and `pc_next` becomes `RESET_VEC + 4`.
- R2: Register 0 always reads as 0, whatever was written to it.
- R3: Both read ports return the committed register contents combinationally. A commit with `wr_en` high writes `wr_data` into `wr_idx`, and the new value is readable right after that edge.
- R4: A commit with `ld_en` high places (`ld_idx`, `ld_data`) in the pending slot, shown on `pend_idx`/`pend_data`. The target register keeps its old value until the next commit or flush.
- R5: At a commit, the pending value is written after the execute write. If both address the same register, the register ends up holding the pending value.
- R6: A pending entry whose target is 0 changes no register.
- R7: A commit with `ld_en` low leaves the pending slot at target 0, value 0.
- R8: On a commit, `pc_prev` takes `pc_cur` and `pc_cur` takes `pc_next`. `pc_next` takes `target_pc` when `target_en` is high, and `pc_next + 4` otherwise.
- R9: A commit with `link_en` high writes the pre-commit `pc_next + 4` into `wr_idx`. This takes priority over `wr_data`.
- R10: `flush` writes the pending value to its target and clears the slot to 0/0. It leaves the PC chain unchanged and performs no execute write. It dominates `commit` in the same cycle.
- R11: With `commit` and `flush` both low, no register, slot or PC changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| commit | input | 1 | One instruction retires this cycle |
| flush | input | 1 | Drain pending load before trap entry |
| rd_a_idx | input | AW | Read port A index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | AW | Read port B index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Execute-stage write enable |
| link_en | input | 1 | Write link address instead of wr_data |
| wr_idx | input | AW | Execute write target |
| wr_data | input | XLEN | Execute write value |
| ld_en | input | 1 | Retiring instruction is a load |
| ld_idx | input | AW | Load target register |
| ld_data | input | XLEN | Load result |
| target_en | input | 1 | Control transfer taken |
| target_pc | input | XLEN | Control transfer destination |
| pend_idx | output | AW | Pending load target |
| pend_data | output | XLEN | Pending load value |
| pc_prev | output | XLEN | Previous PC |
| pc_cur | output | XLEN | Current PC |
| pc_next | output | XLEN | Next PC (delay slot successor) |

## Verification
A corrupted pending slot shows on `pend_idx`/`pend_data` one edge after the commit that loaded it. It shows in the register contents one further commit later. A write-ordering error only becomes visible when a read port addresses the collided register after the second commit, so the stimulus is biased towards a small set of indices to provoke collisions often. PC chain faults appear on the three PC outputs at the very next edge. All outputs and both read ports are compared against a behavioural model after every clock.

// File: rtl/regfile_ldslot.sv
module regfile_ldslot #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int AW = $clog2(NREG),
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic            flush,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic            link_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_idx,
  input  logic [XLEN-1:0] ld_data,
  input  logic            target_en,
  input  logic [XLEN-1:0] target_pc,
  output logic [AW-1:0]   pend_idx,
  output logic [XLEN-1:0] pend_data,
  output logic [XLEN-1:0] pc_prev,
  output logic [XLEN-1:0] pc_cur,
  output logic [XLEN-1:0] pc_next
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] regs [NREG];

  wire             adv      = commit & ~flush;
  wire [XLEN-1:0]  seq_pc   = pc_next + STEP;
  wire [XLEN-1:0]  exec_val = link_en ? seq_pc : wr_data;

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (adv && (wr_en || link_en)) regs[wr_idx] <= exec_val;
      if (adv || flush) regs[pend_idx] <= pend_data;
      regs[0] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_idx  <= '0;
      pend_data <= '0;
    end else if (commit) begin
      pend_idx  <= ld_en ? ld_idx  : '0;
      pend_data <= ld_en ? ld_data : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_prev <= RESET_VEC;
      pc_cur  <= RESET_VEC;
      pc_next <= RESET_VEC + STEP;
    end else if (adv) begin
      pc_prev <= pc_cur;
      pc_cur  <= pc_next;
      pc_next <= target_en ? target_pc : seq_pc;
    end
  end

  p_zero_reads_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  p_chain_shift_r8: assert property (@(posedge clk) disable iff (rst)
    adv |=> (pc_prev == $past(pc_cur)) && (pc_cur == $past(pc_next)));

  p_delay_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !target_en) |=> (pc_next == $past(pc_next) + STEP));

  p_no_load_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld_en) |=> (pend_idx == '0) && (pend_data == '0));

  p_flush_drain_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pend_idx == '0) && $stable(pc_cur) && $stable(pc_next));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!commit && !flush) |=> $stable(pc_cur) && $stable(pend_idx) && $stable(pend_data));
endmodule

// File: tb/sim_regfile_ldslot.sv
module sim_regfile_ldslot;
  localparam int XLEN = 32;
  localparam int AW = 5;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst, commit, flush, wr_en, link_en, ld_en, target_en;
  logic [AW-1:0] rd_a_idx, rd_b_idx, wr_idx, ld_idx, pend_idx;
  logic [31:0] wr_data, ld_data, target_pc, rd_a_data, rd_b_data, pend_data;
  logic [31:0] pc_prev, pc_cur, pc_next;

  regfile_ldslot #(.XLEN(XLEN), .NREG(32), .AW(AW), .RESET_VEC(RVEC)) u0 (
    .clk(clk), .rst(rst), .commit(commit), .flush(flush),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .link_en(link_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .target_en(target_en), .target_pc(target_pc),
    .pend_idx(pend_idx), .pend_data(pend_data),
    .pc_prev(pc_prev), .pc_cur(pc_cur), .pc_next(pc_next));

  int checks = 0, fails = 0;
  logic [31:0] m_reg [32];
  int unsigned m_pidx;
  logic [31:0] m_pdat, m_pp, m_pc, m_pn;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(logic [AW-1:0] i);
    return (i == 0) ? 32'h0 : m_reg[i];
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < 32; i++) m_reg[i] = 0;
      m_pidx = 0; m_pdat = 0; m_pp = RVEC; m_pc = RVEC; m_pn = RVEC + 4;
    end else if (flush) begin
      m_reg[m_pidx] = m_pdat;
      m_reg[0] = 0; m_pidx = 0; m_pdat = 0;
    end else if (commit) begin
      if (link_en) m_reg[wr_idx] = m_pn + 4;
      else if (wr_en) m_reg[wr_idx] = wr_data;
      m_reg[m_pidx] = m_pdat;
      m_reg[0] = 0;
      m_pidx = ld_en ? int'(ld_idx) : 0;
      m_pdat = ld_en ? ld_data : 0;
      m_pp = m_pc; m_pc = m_pn;
      m_pn = target_en ? target_pc : m_pn + 4;
    end
  endtask

  task automatic compare();
    chk("R8 pc_prev", pc_prev, m_pp);
    chk("R8 pc_cur", pc_cur, m_pc);
    chk("R8 pc_next", pc_next, m_pn);
    chk("R4 pend_idx", 32'(pend_idx), 32'(m_pidx));
    chk("R4 pend_data", pend_data, m_pdat);
    chk("R3 rd_a", rd_a_data, mread(rd_a_idx));
    chk("R3 rd_b", rd_b_data, mread(rd_b_idx));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    rst = 0; commit = 0; flush = 0; wr_en = 0; link_en = 0; ld_en = 0; target_en = 0;
    wr_idx = 0; wr_data = 0; ld_idx = 0; ld_data = 0; target_pc = 0;
  endtask

  task automatic instr(bit w, logic [AW-1:0] wi, logic [31:0] wd, bit l, logic [AW-1:0] li, logic [31:0] ld);
    idle(); commit = 1; wr_en = w; wr_idx = wi; wr_data = wd; ld_en = l; ld_idx = li; ld_data = ld;
    step();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    idle(); rst = 1; rd_a_idx = 0; rd_b_idx = 0;
    @(negedge clk); step(); step();
    rd_a_idx = 7; rd_b_idx = 31;
    #1;
    chk("R1 pc_cur", pc_cur, RVEC); chk("R1 pc_next", pc_next, RVEC + 4);
    chk("R1 reg31", rd_b_data, 0); chk("R1 pend", pend_data, 0);
    idle(); rd_a_idx = 5; rd_b_idx = 0;
    // R3 plain write, R2 write to r0 ignored
    instr(1, 5, 32'h1234_5678, 0, 0, 0);
    chk("R3 write visible", rd_a_data, 32'h1234_5678);
    instr(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R2 r0 stays zero", rd_b_data, 0);
    // R4 load delayed by one commit
    instr(0, 0, 0, 1, 5, 32'hAAAA_0001);
    chk("R4 old value before apply", rd_a_data, 32'h1234_5678);
    chk("R4 pend idx", 32'(pend_idx), 5);
    // R5 collision: next instruction writes r5, pending wins
    instr(1, 5, 32'h0000_BEEF, 0, 0, 0);
    chk("R5 pending overrides exec", rd_a_data, 32'hAAAA_0001);
    chk("R7 slot empty", 32'(pend_idx), 0);
    // R6 load to r0
    instr(0, 0, 0, 1, 0, 32'h5555_5555);
    instr(0, 0, 0, 0, 0, 0);
    chk("R6 r0 unaffected", rd_b_data, 0);
    // R9 link and R8 taken target
    rd_a_idx = 31;
    idle(); commit = 1; link_en = 1; wr_idx = 31; wr_data = 32'hDEAD; target_en = 1; target_pc = 32'h0000_4000;
    begin
      logic [31:0] exp_link;
      exp_link = pc_next + 4;
      step();
      chk("R9 link value", rd_a_data, exp_link);
      chk("R8 taken target", pc_next, 32'h0000_4000);
    end
    // R10 flush drains pending, holds PCs, dominates commit
    rd_a_idx = 9;
    instr(0, 0, 0, 1, 9, 32'h0909_0909);
    begin
      logic [31:0] pcsave;
      pcsave = pc_cur;
      idle(); flush = 1; commit = 1; wr_en = 1; wr_idx = 9; wr_data = 32'h1;
      step();
      chk("R10 drained", rd_a_data, 32'h0909_0909);
      chk("R10 pc held", pc_cur, pcsave);
      chk("R10 slot cleared", pend_data, 0);
    end
    // R11 idle hold
    instr(0, 0, 0, 1, 9, 32'h7777_0000);
    idle(); step(); step();
    chk("R11 no apply while idle", rd_a_data, 32'h0909_0909);
    chk("R11 slot held", pend_data, 32'h7777_0000);
    // random traffic compared every cycle
    for (int n = 0; n < 3000; n++) begin
      idle();
      rst       = ($urandom_range(0, 199) == 0);
      commit    = ($urandom_range(0, 3) != 0);
      flush     = ($urandom_range(0, 15) == 0);
      wr_en     = $urandom_range(0, 1);
      link_en   = ($urandom_range(0, 9) == 0);
      wr_idx    = AW'($urandom_range(0, 7));
      wr_data   = $urandom;
      ld_en     = $urandom_range(0, 1);
      ld_idx    = AW'($urandom_range(0, 7));
      ld_data   = $urandom;
      target_en = ($urandom_range(0, 3) == 0);
      target_pc = $urandom & 32'hFFFF_FFFC;
      rd_a_idx  = AW'($urandom_range(0, 7));
      rd_b_idx  = AW'($urandom_range(0, 31));
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule